// File: doc/BRIEF.md
# Hall-Commutated Three-Phase Gate Sequencer

This block sits between the rotor-position sensors of a three-phase brushless motor and the gate drivers of its six-switch bridge. It turns three Hall-sensor levels into a pair of gate enables for each phase, a high side and a low side. The inputs are first synchronised, then filtered so that short glitches are rejected. Each of the six valid rotor positions turns on one high-side switch and one low-side switch on two different phases, and leaves the third phase floating. A direction input reverses the energised pair.

Control inputs change this basic pattern, in a fixed order of priority. The active-low brake shorts the winding through all three low sides. A global fault input or an impossible Hall code turns every gate off. A chop-off request, from an external PWM source or from the current limiter, puts the bridge into slow decay: the driven high side turns off and its own low side turns on to carry the recirculating current. When the supply-overvoltage flag is set, that extra low side stays off. Every half-bridge enforces a dead time before a gate turns on against its complement. Two speed outputs follow rotor movement. Timing is set in nanoseconds and converted to clock cycles from the system clock frequency, which defaults to 10 MHz.

Top module: `hall_gate_seq`

## Requirements
- R1: At most one high-side gate is on in any cycle, and no phase ever has its high and low gate on in the same cycle.
- R2: With brake_n high, fault low, both chop inputs low and dir_fwd=1, the filtered code {hall_in[2]=A, hall_in[1]=B, hall_in[0]=C} drives these (high, low) pairs: 100→(A,B), 110→(A,C), 010→(B,C), 011→(B,A), 001→(C,A), 101→(C,B). All other gates are off. Gate bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R3: With dir_fwd=0, every valid code drives the same two phases with high and low swapped.
- R4: Hall codes 000 and 111 turn all six gates off, whatever the value of dir_fwd.
- R5: brake_n low turns all high gates off on the next clock. After the dead time it turns all three low gates on, regardless of Hall code, dir_fwd, chop inputs or fault.
- R6: fault high with brake_n high turns all gates off on the next clock. When fault clears, the gates resume the pattern of the current Hall code.
- R7: During chop-off (chop_ext or chop_lim high), with ov_flag low, all high gates are off and the low gates of both energised phases are on.
- R8: During chop-off with ov_flag high, only the low gate of the phase that was already low stays on. The gate enables then show at most one low gate on.
- R9: After a gate of a phase turns off, the complementary gate of that phase stays off for at least DEAD_CYC sampled cycles.
- R10: A Hall input pulse shorter than FILT_CYC cycles changes no gate output and no speed output.
- R11: fg_edge toggles once for each change of the filtered Hall code, and fg_a follows filtered Hall A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Raw Hall levels, bit 2 = A, bit 1 = B, bit 0 = C |
| dir_fwd | input | 1 | 1 = forward sequence, 0 = reverse |
| brake_n | input | 1 | Active-low brake |
| chop_ext | input | 1 | External chop-off request (high = off interval) |
| chop_lim | input | 1 | Current-limiter off-time request |
| ov_flag | input | 1 | Supply overvoltage, inhibits synchronous rectification |
| fault | input | 1 | Global fault (thermal or undervoltage) |
| gate_hi | output | 3 | High-side gate enables, bit 0 = A |
| gate_lo | output | 3 | Low-side gate enables, bit 0 = A |
| fg_edge | output | 1 | Toggles on each filtered Hall change |
| fg_a | output | 1 | Filtered Hall A level |

## Verification
The assertions take dir_fwd, brake_n, the chop inputs, ov_flag and fault to be synchronous to clk. Only hall_in passes through the synchroniser. The fg_edge property also relies on the filtered code changing at most once per cycle. The bench drives every input on the falling clock edge and samples on the falling edge as well, so all controls meet that assumption. It moves the Hall inputs only after the filter and dead time have settled, except in the glitch scenario, where the pulse is kept deliberately shorter than the filter window.

// File: rtl/hgs_pkg.sv
package hgs_pkg;

    typedef enum logic [1:0] {
        PH_FLOAT = 2'd0,
        PH_HIGH  = 2'd1,
        PH_LOW   = 2'd2
    } ph_req_e;

    localparam int NUM_PH = 3;

    typedef ph_req_e [NUM_PH-1:0] ph_vec_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] hi_ph;
        logic [1:0] lo_ph;
    } step_t;

    // code is {A,B,C}; phase index 0=A, 1=B, 2=C
    function automatic step_t step_lookup(input logic [2:0] code, input logic fwd);
        step_t s;
        logic [1:0] p, q;
        s.valid = 1'b1;
        p = 2'd0;
        q = 2'd0;
        case (code)
            3'b100: begin p = 2'd0; q = 2'd1; end
            3'b110: begin p = 2'd0; q = 2'd2; end
            3'b010: begin p = 2'd1; q = 2'd2; end
            3'b011: begin p = 2'd1; q = 2'd0; end
            3'b001: begin p = 2'd2; q = 2'd0; end
            3'b101: begin p = 2'd2; q = 2'd1; end
            default: s.valid = 1'b0;
        endcase
        s.hi_ph = fwd ? p : q;
        s.lo_ph = fwd ? q : p;
        return s;
    endfunction

    function automatic int unsigned ns_to_cycles(input int unsigned clk_khz,
                                                 input int unsigned ns);
        return (clk_khz * ns) / 1000000;
    endfunction

endpackage

// File: rtl/hgs_hall_filter.sv
module hgs_hall_filter #(
    parameter int FILT_CYC = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_raw,
    output logic [2:0] hall_f
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

    logic [2:0] s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= hall_raw;
            s2 <= s1;
        end
    end

    for (genvar i = 0; i < 3; i++) begin : g_bit
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt       <= '0;
                hall_f[i] <= 1'b0;
            end else if (s2[i] == hall_f[i]) begin
                cnt <= '0;
            end else if (cnt == LIM) begin
                cnt       <= '0;
                hall_f[i] <= s2[i];
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hgs_request.sv
module hgs_request
    import hgs_pkg::*;
(
    input  logic [2:0] hall_f,
    input  logic       dir_fwd,
    input  logic       brake_n,
    input  logic       chop_ext,
    input  logic       chop_lim,
    input  logic       ov_flag,
    input  logic       fault,
    output ph_vec_t    req
);
    step_t st;
    logic  chop;

    always_comb begin
        st   = step_lookup(hall_f, dir_fwd);
        chop = chop_ext | chop_lim;
        for (int i = 0; i < NUM_PH; i++) req[i] = PH_FLOAT;
        if (!brake_n) begin
            for (int i = 0; i < NUM_PH; i++) req[i] = PH_LOW;
        end else if (!fault && st.valid) begin
            req[st.lo_ph] = PH_LOW;
            if (!chop) req[st.hi_ph] = PH_HIGH;
            else if (!ov_flag) req[st.hi_ph] = PH_LOW;
        end
    end

endmodule

// File: rtl/hgs_dead_leg.sv
module hgs_dead_leg
    import hgs_pkg::*;
#(
    parameter int DEAD_CYC = 10
) (
    input  logic    clk,
    input  logic    rst,
    input  ph_req_e req,
    output logic    gh,
    output logic    gl
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DMAX = CW'(DEAD_CYC);

    logic [CW-1:0] lo_off, hi_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            gh     <= 1'b0;
            gl     <= 1'b0;
            lo_off <= '0;
            hi_off <= '0;
        end else begin
            gh     <= (req == PH_HIGH) && !gl && (lo_off == DMAX);
            gl     <= (req == PH_LOW)  && !gh && (hi_off == DMAX);
            lo_off <= gl ? '0 : ((lo_off == DMAX) ? DMAX : lo_off + 1'b1);
            hi_off <= gh ? '0 : ((hi_off == DMAX) ? DMAX : hi_off + 1'b1);
        end
    end

    assert_no_shoot_R1: assert property (@(posedge clk) disable iff (rst)
        !(gh && gl));
    assert_hi_after_lo_off_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(gh) |-> !$past(gl));
    assert_lo_after_hi_off_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(gl) |-> !$past(gh));

endmodule

// File: rtl/hgs_speed_fb.sv
module hgs_speed_fb (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_f,
    output logic       fg_edge,
    output logic       fg_a
);
    logic [2:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= '0;
            fg_edge <= 1'b0;
        end else begin
            prev <= hall_f;
            if (prev != hall_f) fg_edge <= ~fg_edge;
        end
    end

    assign fg_a = hall_f[2];

    assert_fg_toggle_R11: assert property (@(posedge clk) disable iff (rst)
        (hall_f != $past(hall_f)) |=> (fg_edge != $past(fg_edge)));

endmodule

// File: rtl/hall_gate_seq.sv
module hall_gate_seq
    import hgs_pkg::*;
#(
    parameter int CLK_KHZ = 10000,
    parameter int DEAD_NS = 1000,
    parameter int FILT_NS = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       dir_fwd,
    input  logic       brake_n,
    input  logic       chop_ext,
    input  logic       chop_lim,
    input  logic       ov_flag,
    input  logic       fault,
    output logic [2:0] gate_hi,
    output logic [2:0] gate_lo,
    output logic       fg_edge,
    output logic       fg_a
);
    localparam int DEAD_CYC = ns_to_cycles(CLK_KHZ, DEAD_NS);
    localparam int FILT_CYC = ns_to_cycles(CLK_KHZ, FILT_NS);

    logic [2:0] hall_f;
    ph_vec_t    req;

    hgs_hall_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk(clk), .rst(rst), .hall_raw(hall_in), .hall_f(hall_f)
    );

    hgs_request u_req (
        .hall_f(hall_f), .dir_fwd(dir_fwd), .brake_n(brake_n),
        .chop_ext(chop_ext), .chop_lim(chop_lim), .ov_flag(ov_flag),
        .fault(fault), .req(req)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
        hgs_dead_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk(clk), .rst(rst), .req(req[p]),
            .gh(gate_hi[p]), .gl(gate_lo[p])
        );
    end

    hgs_speed_fb u_fg (
        .clk(clk), .rst(rst), .hall_f(hall_f), .fg_edge(fg_edge), .fg_a(fg_a)
    );

    assert_single_high_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_hi));
    assert_brake_high_off_R5: assert property (@(posedge clk) disable iff (rst)
        !brake_n |=> (gate_hi == 3'b000));
    assert_fault_off_R6: assert property (@(posedge clk) disable iff (rst)
        (brake_n && fault) |=> (gate_hi == 3'b000 && gate_lo == 3'b000));
    assert_bad_code_off_R4: assert property (@(posedge clk) disable iff (rst)
        (brake_n && (hall_f == 3'b000 || hall_f == 3'b111))
        |=> (gate_hi == 3'b000 && gate_lo == 3'b000));
    assert_ov_single_low_R8: assert property (@(posedge clk) disable iff (rst)
        (brake_n && ov_flag) |=> ($countones(gate_lo) <= 1));

endmodule

// File: tb/tb_hall_gate_seq.sv
module tb_hall_gate_seq;
    localparam int CLK_PERIOD = 100;
    localparam int DEAD_CYC = 10;
    localparam int FILT_CYC = 20;
    localparam int SETTLE = FILT_CYC + DEAD_CYC + 20;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] hall_in;
    logic       dir_fwd, brake_n, chop_ext, chop_lim, ov_flag, fault;
    logic [2:0] gate_hi, gate_lo;
    logic       fg_edge, fg_a;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hall_gate_seq dut (
        .clk(clk), .rst(rst), .hall_in(hall_in), .dir_fwd(dir_fwd),
        .brake_n(brake_n), .chop_ext(chop_ext), .chop_lim(chop_lim),
        .ov_flag(ov_flag), .fault(fault), .gate_hi(gate_hi),
        .gate_lo(gate_lo), .fg_edge(fg_edge), .fg_a(fg_a)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected (hi, lo) one-hot masks, bit0 = A
    function automatic logic [5:0] expect_pair(input logic [2:0] code, input logic fwd);
        logic [2:0] h, l;
        case (code)
            3'b100: begin h = 3'b001; l = 3'b010; end
            3'b110: begin h = 3'b001; l = 3'b100; end
            3'b010: begin h = 3'b010; l = 3'b100; end
            3'b011: begin h = 3'b010; l = 3'b001; end
            3'b001: begin h = 3'b100; l = 3'b001; end
            3'b101: begin h = 3'b100; l = 3'b010; end
            default: begin h = 3'b000; l = 3'b000; end
        endcase
        return fwd ? {h, l} : {l, h};
    endfunction

    task automatic t_reset;
        check(gate_hi == 0 && gate_lo == 0, "R4", "reset gates",
              {2'b0, gate_hi, gate_lo}, 8'h00);
        check(fg_edge == 0 && fg_a == 0, "R11", "reset fg", {6'b0, fg_edge, fg_a}, 8'h00);
    endtask

    task automatic t_sweep(input logic fwd);
        logic [2:0] seq [6] = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101};
        dir_fwd = fwd;
        for (int i = 0; i < 6; i++) begin
            logic [5:0] e;
            hall_in = seq[i];
            tick(SETTLE);
            e = expect_pair(seq[i], fwd);
            check({gate_hi, gate_lo} == e, fwd ? "R2" : "R3", "commutation",
                  {2'b0, gate_hi, gate_lo}, {2'b0, e});
        end
    endtask

    task automatic t_invalid;
        for (int d = 0; d < 2; d++) begin
            dir_fwd = d[0];
            hall_in = 3'b111; tick(SETTLE);
            check(gate_hi == 0 && gate_lo == 0, "R4", "code 111",
                  {2'b0, gate_hi, gate_lo}, 8'h00);
            hall_in = 3'b000; tick(SETTLE);
            check(gate_hi == 0 && gate_lo == 0, "R4", "code 000",
                  {2'b0, gate_hi, gate_lo}, 8'h00);
        end
        dir_fwd = 1'b1;
    endtask

    task automatic t_brake;
        hall_in = 3'b110; tick(SETTLE);
        brake_n = 1'b0; tick(1);
        check(gate_hi == 0, "R5", "brake high off next clk", {5'b0, gate_hi}, 8'h00);
        tick(SETTLE);
        check(gate_hi == 0 && gate_lo == 3'b111, "R5", "brake all low",
              {2'b0, gate_hi, gate_lo}, 8'h07);
        fault = 1'b1; chop_ext = 1'b1; hall_in = 3'b111; dir_fwd = 1'b0;
        tick(SETTLE);
        check(gate_hi == 0 && gate_lo == 3'b111, "R5", "brake over fault/invalid",
              {2'b0, gate_hi, gate_lo}, 8'h07);
        brake_n = 1'b1; fault = 1'b0; chop_ext = 1'b0; dir_fwd = 1'b1;
        hall_in = 3'b100; tick(SETTLE);
    endtask

    task automatic t_fault;
        hall_in = 3'b010; tick(SETTLE);
        fault = 1'b1; tick(1);
        check(gate_hi == 0 && gate_lo == 0, "R6", "fault off next clk",
              {2'b0, gate_hi, gate_lo}, 8'h00);
        hall_in = 3'b011; tick(SETTLE);
        check(gate_hi == 0 && gate_lo == 0, "R6", "fault holds off",
              {2'b0, gate_hi, gate_lo}, 8'h00);
        fault = 1'b0; tick(SETTLE);
        check({gate_hi, gate_lo} == expect_pair(3'b011, 1'b1), "R6", "resume after fault",
              {2'b0, gate_hi, gate_lo}, {2'b0, expect_pair(3'b011, 1'b1)});
    endtask

    task automatic t_chop;
        hall_in = 3'b100; dir_fwd = 1'b1; tick(SETTLE);
        chop_ext = 1'b1; tick(SETTLE);
        check(gate_hi == 0 && gate_lo == 3'b011, "R7", "ext chop slow decay",
              {2'b0, gate_hi, gate_lo}, 8'h03);
        chop_ext = 1'b0; tick(SETTLE);
        chop_lim = 1'b1; tick(SETTLE);
        check(gate_hi == 0 && gate_lo == 3'b011, "R7", "limit chop slow decay",
              {2'b0, gate_hi, gate_lo}, 8'h03);
        ov_flag = 1'b1; tick(SETTLE);
        check(gate_hi == 0 && gate_lo == 3'b010, "R8", "ov inhibits rectify",
              {2'b0, gate_hi, gate_lo}, 8'h02);
        chop_lim = 1'b0; tick(SETTLE);
        check({gate_hi, gate_lo} == 6'b001_010, "R8", "ov drive normal",
              {2'b0, gate_hi, gate_lo}, 8'h0A);
        ov_flag = 1'b0; tick(SETTLE);
    endtask

    task automatic t_dead;
        int gap;
        bool_wait: begin end
        hall_in = 3'b100; dir_fwd = 1'b1; tick(SETTLE);
        dir_fwd = 1'b0;
        gap = 0;
        while (gate_hi[0]) tick(1);
        while (!gate_lo[0] && gap < 100) begin
            check(!gate_hi[0], "R9", "no overlap A", {7'b0, gate_hi[0]}, 8'h00);
            gap++;
            tick(1);
        end
        check(gap >= DEAD_CYC && gap < DEAD_CYC + 4, "R9", "dead gap A",
              8'(gap), 8'(DEAD_CYC));
        tick(SETTLE);
        check({gate_hi, gate_lo} == expect_pair(3'b100, 1'b0), "R3", "after reversal",
              {2'b0, gate_hi, gate_lo}, {2'b0, expect_pair(3'b100, 1'b0)});
        dir_fwd = 1'b1; tick(SETTLE);
    endtask

    task automatic t_glitch;
        logic [5:0] g0;
        logic       f0;
        bit         ok;
        hall_in = 3'b100; tick(SETTLE);
        g0 = {gate_hi, gate_lo}; f0 = fg_edge; ok = 1'b1;
        hall_in = 3'b000;
        for (int i = 0; i < FILT_CYC / 2; i++) begin
            tick(1);
            if ({gate_hi, gate_lo} != g0 || fg_edge != f0) ok = 1'b0;
        end
        hall_in = 3'b100;
        for (int i = 0; i < SETTLE; i++) begin
            tick(1);
            if ({gate_hi, gate_lo} != g0 || fg_edge != f0 || !fg_a) ok = 1'b0;
        end
        check(ok, "R10", "short pulse rejected", {2'b0, gate_hi, gate_lo}, {2'b0, g0});
    endtask

    task automatic t_fg;
        logic f0;
        hall_in = 3'b100; tick(SETTLE);
        check(fg_a == 1'b1, "R11", "fg_a follows A high", {7'b0, fg_a}, 8'h01);
        f0 = fg_edge;
        hall_in = 3'b110; tick(SETTLE);
        check(fg_edge == ~f0, "R11", "fg toggles on B", {7'b0, fg_edge}, {7'b0, ~f0});
        hall_in = 3'b010; tick(SETTLE);
        check(fg_edge == f0, "R11", "fg toggles on A", {7'b0, fg_edge}, {7'b0, f0});
        check(fg_a == 1'b0, "R11", "fg_a follows A low", {7'b0, fg_a}, 8'h00);
    endtask

    initial begin
        rst = 1'b1; hall_in = 3'b000; dir_fwd = 1'b1; brake_n = 1'b1;
        chop_ext = 1'b0; chop_lim = 1'b0; ov_flag = 1'b0; fault = 1'b0;
        tick(4);
        t_reset();
        rst = 1'b0;
        tick(2);
        t_sweep(1'b1);
        t_sweep(1'b0);
        t_invalid();
        t_brake();
        t_fault();
        t_chop();
        t_dead();
        t_glitch();
        t_fg();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule